// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides when an embedded bus master may lend its external bus to an outside master, and when it must take the bus back. An outside device raises an asynchronous release request. The arbiter synchronizes that request and tells the internal bus sequencer not to begin new work. It then waits for the current indivisible transaction to finish. Only then does it turn off the pin drivers and raise the grant acknowledge.

The sequencer reports four busy conditions: a bus cycle in progress, a cache fill or write-back burst, an atomic read-modify-write, and an access split over a narrow data bus. The bus is never released while any of them is high.

While the bus is lent out, the block watches its internal needs (refresh and interrupt service). If any of them rises, it asks the outside master to hand the bus back. When the outside master drops its request, the grant and the request-back drop together. The sequencer is stalled for one more cycle and then resumes.

Top module: `bus_release_arbiter`

## Requirements
- R1: No grant is given while `cyc_busy_i` is high. `seq_hold_o` is high from the third clock after the request rises until the bus is owned again.
- R2: No grant is given while `burst_lock_i` (cache fill or write-back burst) is high.
- R3: No grant is given while `atomic_lock_i` (between the read and the write of a test-and-set) is high.
- R4: No grant is given while `split_lock_i` (a wide access split into narrow bus cycles) is high.
- R5: If the request is withdrawn before the grant, no grant appears. Within three clocks of the withdrawal, `seq_hold_o` is low again.
- R6: While the bus is released, `grant_o`=1, `pin_oe_o`=0 and `seq_hold_o`=1. At all other times `pin_oe_o`=1.
- R7: While released, `reclaim_o` rises one clock after any bit of `need_i` is high. Bit 0 is refresh and bit 1 is interrupt. Once set, it stays high until the grant drops, even if `need_i` returns to 0.
- R8: `grant_o` and `reclaim_o` fall on the same clock edge, the third edge after `ext_req_i` is negated (two synchronizer stages). On the second edge the grant is still high.
- R9: `seq_hold_o` stays high for exactly one clock after `grant_o` falls, then goes low.
- R10: During and after reset, `grant_o`=0, `reclaim_o`=0, `seq_hold_o`=0 and `pin_oe_o`=1.
- R11: With all busy inputs low, `grant_o` rises on the fourth clock edge after `ext_req_i` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req_i | input | 1 | Asynchronous bus release request from the outside master |
| cyc_busy_i | input | 1 | A bus cycle is in progress |
| burst_lock_i | input | 1 | A cache fill or write-back burst is in progress |
| atomic_lock_i | input | 1 | An atomic read-modify-write is between its read and its write |
| split_lock_i | input | 1 | A wide access is partway through its narrow bus cycles |
| need_i | input | NEED_W | Internal needs for the bus (bit 0 refresh, bit 1 interrupt) |
| grant_o | output | 1 | Bus release acknowledge to the outside master |
| reclaim_o | output | 1 | Asks the outside master to give the bus back |
| seq_hold_o | output | 1 | Tells the sequencer to start no new transaction |
| pin_oe_o | output | 1 | Output enable for the address, data and strobe drivers |

## Verification
The assertions take for granted that the sequencer, once held, finishes its current transaction and raises no new busy flag. They also assume that the outside master holds its request steady for longer than the synchronizer depth. The stimulus sweeps every combination of the four busy flags. It changes them only on falling clock edges and clears them while the request is held, so a grant is always reachable. Each request and each withdrawal is held for at least three clocks. `need_i` is driven only while the bus is lent, and every pattern of it is used.

// File: rtl/brel_pkg.sv
package brel_pkg;
   typedef enum logic [1:0] {
      ST_OWN    = 2'd0,
      ST_DRAIN  = 2'd1,
      ST_YIELD  = 2'd2,
      ST_RESUME = 2'd3
   } brel_state_e;
endpackage

// File: rtl/brel_sync.sv
module brel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh_q[0] <= 1'b0;
               else        sh_q[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh_q[s] <= 1'b0;
               else        sh_q[s] <= sh_q[s-1];
         end
      end
   endgenerate

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/brel_boundary.sv
module brel_boundary (
   input  logic cyc_busy_i,
   input  logic burst_lock_i,
   input  logic atomic_lock_i,
   input  logic split_lock_i,
   output logic at_edge_o
);
   // The bus may change hands only when no indivisible work is open.
   assign at_edge_o = ~(cyc_busy_i | burst_lock_i | atomic_lock_i | split_lock_i);
endmodule

// File: rtl/brel_fsm.sv
module brel_fsm
   import brel_pkg::*;
#(
   parameter int NEED_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_s_i,
   input  logic              at_edge_i,
   input  logic [NEED_W-1:0] need_i,
   output logic              grant_o,
   output logic              reclaim_o,
   output logic              seq_hold_o,
   output logic              pin_oe_o
);
   brel_state_e state_q, state_d;
   logic        reclaim_q, reclaim_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OWN:    if (req_s_i) state_d = ST_DRAIN;
         ST_DRAIN:  if (!req_s_i) state_d = ST_OWN;
                    else if (at_edge_i) state_d = ST_YIELD;
         ST_YIELD:  if (!req_s_i) state_d = ST_RESUME;
         ST_RESUME: state_d = ST_OWN;
         default:   state_d = ST_OWN;
      endcase
   end

   // Request-back latches while lent and clears on the edge the grant drops.
   always_comb begin
      reclaim_d = 1'b0;
      if (state_q == ST_YIELD && req_s_i)
         reclaim_d = reclaim_q | (|need_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OWN;
         reclaim_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         reclaim_q <= reclaim_d;
      end
   end

   assign grant_o    = (state_q == ST_YIELD);
   assign pin_oe_o   = (state_q != ST_YIELD);
   assign seq_hold_o = (state_q != ST_OWN);
   assign reclaim_o  = reclaim_q;
endmodule

// File: rtl/bus_release_arbiter.sv
module bus_release_arbiter #(
   parameter int SYNC_STAGES = 2,
   parameter int NEED_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_req_i,
   input  logic              cyc_busy_i,
   input  logic              burst_lock_i,
   input  logic              atomic_lock_i,
   input  logic              split_lock_i,
   input  logic [NEED_W-1:0] need_i,
   output logic              grant_o,
   output logic              reclaim_o,
   output logic              seq_hold_o,
   output logic              pin_oe_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NEED_W < 1) begin : g_bad_need
         $error("NEED_W must be at least 1");
      end
   endgenerate

   logic req_s;
   logic at_edge;

   brel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_req_i),
      .q_o   (req_s)
   );

   brel_boundary u_boundary (
      .cyc_busy_i    (cyc_busy_i),
      .burst_lock_i  (burst_lock_i),
      .atomic_lock_i (atomic_lock_i),
      .split_lock_i  (split_lock_i),
      .at_edge_o     (at_edge)
   );

   brel_fsm #(.NEED_W(NEED_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_s_i    (req_s),
      .at_edge_i  (at_edge),
      .need_i     (need_i),
      .grant_o    (grant_o),
      .reclaim_o  (reclaim_o),
      .seq_hold_o (seq_hold_o),
      .pin_oe_o   (pin_oe_o)
   );
endmodule

// File: rtl/brel_checker.sv
module brel_checker #(
   parameter int NEED_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_busy_i,
   input logic              burst_lock_i,
   input logic              atomic_lock_i,
   input logic              split_lock_i,
   input logic [NEED_W-1:0] need_i,
   input logic              grant_o,
   input logic              reclaim_o,
   input logic              seq_hold_o,
   input logic              pin_oe_o
);
   assert_no_grant_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_o) |-> !$past(cyc_busy_i));
   assert_no_grant_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_o) |-> !$past(burst_lock_i));
   assert_no_grant_atomic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_o) |-> !$past(atomic_lock_i));
   assert_no_grant_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_o) |-> !$past(split_lock_i));
   assert_released_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> (!pin_oe_o && seq_hold_o));
   assert_owned_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_o |-> pin_oe_o);
   assert_reclaim_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reclaim_o) |-> ($past(|need_i) && $past(grant_o)));
   assert_reclaim_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reclaim_o && grant_o) |=> (reclaim_o == grant_o));
   assert_reclaim_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reclaim_o |-> grant_o);
   assert_hold_after_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grant_o) |-> seq_hold_o);
   assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grant_o) |=> !seq_hold_o);
endmodule

bind bus_release_arbiter brel_checker #(.NEED_W(NEED_W)) u_brel_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cyc_busy_i    (cyc_busy_i),
   .burst_lock_i  (burst_lock_i),
   .atomic_lock_i (atomic_lock_i),
   .split_lock_i  (split_lock_i),
   .need_i        (need_i),
   .grant_o       (grant_o),
   .reclaim_o     (reclaim_o),
   .seq_hold_o    (seq_hold_o),
   .pin_oe_o      (pin_oe_o)
);

// File: tb/bus_release_arbiter_bench.sv
module bus_release_arbiter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_req_i = 1'b0;
   logic       cyc_busy_i = 1'b0;
   logic       burst_lock_i = 1'b0;
   logic       atomic_lock_i = 1'b0;
   logic       split_lock_i = 1'b0;
   logic [1:0] need_i = 2'b00;
   logic       grant_o, reclaim_o, seq_hold_o, pin_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bus_release_arbiter u_bus_release_arbiter (
      .clk (clk), .rst_n (rst_n), .ext_req_i (ext_req_i),
      .cyc_busy_i (cyc_busy_i), .burst_lock_i (burst_lock_i),
      .atomic_lock_i (atomic_lock_i), .split_lock_i (split_lock_i),
      .need_i (need_i), .grant_o (grant_o), .reclaim_o (reclaim_o),
      .seq_hold_o (seq_hold_o), .pin_oe_o (pin_oe_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", what, act, exp, $time);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      check(grant_o, 1'b0, "R10 grant in reset");
      check(reclaim_o, 1'b0, "R10 reclaim in reset");
      check(seq_hold_o, 1'b0, "R10 hold in reset");
      check(pin_oe_o, 1'b1, "R10 oe in reset");
      rst_n = 1'b1;
      tick(2);
      check(grant_o, 1'b0, "R10 grant after reset");
      check(pin_oe_o, 1'b1, "R10 oe after reset");

      // Every combination of the four busy flags, each with one need pattern.
      for (int m = 0; m < 16; m++) begin
         logic [1:0] nv;
         nv = 2'(m % 4);
         {split_lock_i, atomic_lock_i, burst_lock_i, cyc_busy_i} = 4'(m);
         ext_req_i = 1'b1;
         tick(3);
         check(seq_hold_o, 1'b1, "R1 hold while draining");
         check(grant_o, 1'b0, "R11 no grant before fourth edge");
         tick(1);
         check(grant_o, (m == 0), "R11 grant on fourth edge");
         tick(3);
         if (m != 0) begin
            if (m[0])      check(grant_o, 1'b0, "R1 busy blocks release");
            else if (m[1]) check(grant_o, 1'b0, "R2 burst blocks release");
            else if (m[2]) check(grant_o, 1'b0, "R3 atomic blocks release");
            else           check(grant_o, 1'b0, "R4 split blocks release");
            check(pin_oe_o, 1'b1, "R6 drivers on while blocked");
            {split_lock_i, atomic_lock_i, burst_lock_i, cyc_busy_i} = 4'b0;
            tick(1);
            check(grant_o, 1'b1, "R1 grant once boundary reached");
         end
         check(pin_oe_o, 1'b0, "R6 drivers off while released");
         check(seq_hold_o, 1'b1, "R6 hold while released");
         need_i = nv;
         tick(1);
         check(reclaim_o, (nv != 2'b00), "R7 reclaim follows need");
         need_i = 2'b00;
         tick(2);
         check(reclaim_o, (nv != 2'b00), "R7 reclaim sticky");
         ext_req_i = 1'b0;
         tick(2);
         check(grant_o, 1'b1, "R8 grant held two edges after negation");
         check(reclaim_o, (nv != 2'b00), "R8 reclaim held two edges");
         tick(1);
         check(grant_o, 1'b0, "R8 grant drops third edge");
         check(reclaim_o, 1'b0, "R8 reclaim drops with grant");
         check(seq_hold_o, 1'b1, "R9 hold one cycle after drop");
         check(pin_oe_o, 1'b1, "R6 drivers back on");
         tick(1);
         check(seq_hold_o, 1'b0, "R9 hold cleared");
         tick(2);
      end

      // Request withdrawn while the sequencer is still busy.
      cyc_busy_i = 1'b1;
      ext_req_i = 1'b1;
      tick(4);
      check(seq_hold_o, 1'b1, "R5 hold while pending");
      ext_req_i = 1'b0;
      tick(3);
      check(seq_hold_o, 1'b0, "R5 hold released on withdrawal");
      check(grant_o, 1'b0, "R5 no grant on withdrawal");
      cyc_busy_i = 1'b0;
      tick(4);
      check(grant_o, 1'b0, "R5 no late grant");
      check(pin_oe_o, 1'b1, "R5 drivers stay on");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule